// File: doc/BRIEF.md
# Multicycle Post-Increment Load Controller

This block is a small slice of a multicycle processor core that runs two instructions. The first is a plain word load that adds a sign-extended offset to a base register. The second is a load that does the same thing and also writes the base register plus four back into the base register. The core holds its own program counter, an instruction register, two operand latches, an ALU result latch, a memory data latch and a 32-entry register file. One memory port serves both instruction fetch and data fetch, and a single control state machine sequences the work.

The base increment is computed on the ALU during the memory-read cycle, because the ALU is otherwise idle then. The parameter `DUAL_WB` chooses how the two results of the post-increment load reach the register file. With `DUAL_WB = 1` both results are written in one cycle through a second write port. With `DUAL_WB = 0` they are written in two consecutive cycles through one port. The `done` output pulses in the cycle of the last register write of each completed instruction.

Top module: `mcl_core`

## Requirements
- R1: The instruction word is split into opcode [31:26], base register [25:21], destination register [20:16] and offset [15:0]. Opcode 6'b100011 is the plain load. Its data read is issued, with `mem_data_rd` high, at base plus the sign-extended offset, and the word read is written to the destination register.
- R2: While reset is high, the PC, all datapath latches and all registers are zero and the state machine is held in fetch. During that time `mem_addr` is 0 and `done` and `mem_data_rd` are low. Each fetch reads the word at the PC and advances the PC by 4.
- R3: Opcode 6'b111111 is the post-increment load. Its data read is issued at base plus the sign-extended offset, and afterwards the base register holds its old value plus 4, whatever the offset.
- R4: The offset is a signed 16-bit value, so a negative offset lowers the data address.
- R5: With `DUAL_WB = 1`, a post-increment load takes 5 cycles from fetch to `done`, and both registers are written in the `done` cycle.
- R6: With `DUAL_WB = 0`, a post-increment load takes 6 cycles. The loaded word is written first, and the base register is written in the next cycle, which is the `done` cycle.
- R7: A plain load takes 5 cycles, with `done` in its fifth cycle, and the next fetch follows immediately.
- R8: If the base and destination registers of a post-increment load are the same register, then with `DUAL_WB = 1` the register ends up holding the loaded word, and with `DUAL_WB = 0` it ends up holding the old base plus 4.
- R9: Register 0 always reads as zero, and writes to it from either write path have no effect.
- R10: Any other opcode returns the machine to fetch after the decode cycle, 2 cycles in all. It makes no data read, writes no register and raises no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 32 | Byte address to memory; bits 1:0 are ignored by the word-addressed memory |
| mem_rdata | input | 32 | Word read at `mem_addr`, available in the same cycle |
| mem_data_rd | output | 1 | High when the current access is a data read rather than an instruction fetch |
| done | output | 1 | One-cycle pulse in the final write-back cycle of a load |

## Verification
Two copies of the core, one in each write-back mode, run one program in lockstep. The program chains each loaded value or incremented base into the address of a later load, so every register result shows up on `mem_addr` during a later data read. The program mixes positive and negative offsets, a post-increment load whose base and destination are the same register (whose later address separates the two modes), writes aimed at register 0, and an undefined opcode. The cycle of each `done` pulse is also compared with a count built from the per-instruction lengths, which separates 5-, 6- and 2-cycle sequencing and shows that the undefined opcode adds only two cycles.

// File: rtl/mcl_pkg.sv
package mcl_pkg;
    localparam int XLEN = 32;

    localparam logic [5:0] OP_LOAD   = 6'b100011;
    localparam logic [5:0] OP_LOADPI = 6'b111111;

    // encodings 0..4, 12 and 13 are the state numbers of the sequence
    typedef enum logic [3:0] {
        S_FETCH  = 4'd0,
        S_DECODE = 4'd1,
        S_ADDR   = 4'd2,
        S_MEM    = 4'd3,
        S_WBLOAD = 4'd4,
        S_WBBOTH = 4'd12,
        S_WBBASE = 4'd13
    } state_t;

    typedef struct packed {
        logic [5:0]  op;
        logic [4:0]  rs;
        logic [4:0]  rt;
        logic [15:0] imm;
    } instr_t;

    typedef struct packed {
        logic       ir_we;
        logic       pc_we;
        logic       ab_we;
        logic       aluout_we;
        logic       mdr_we;
        logic       iord;
        logic       src_a;      // 0: PC, 1: A
        logic [1:0] src_b;      // 00: B, 01: 4, 1x: offset
        logic [1:0] alu_op;     // 00: add, 01: subtract
        logic [1:0] reg_dst;    // 00: [20:16], 01: [15:11], 10: [25:21]
        logic       mem_to_reg;
        logic       reg_we;
        logic       reg_we2;
        logic       done;
    } ctl_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic logic op_known(input logic [5:0] op);
        return (op == OP_LOAD) || (op == OP_LOADPI);
    endfunction
endpackage

// File: rtl/mcl_regfile.sv
module mcl_regfile #(
    parameter int W = 32,
    parameter int N = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we1,
    input  logic [AW-1:0] wa1,
    input  logic [W-1:0]  wd1,
    input  logic          we2,
    input  logic [AW-1:0] wa2,
    input  logic [W-1:0]  wd2
);
    logic [W-1:0] rf [N];

    for (genvar i = 0; i < N; i++) begin : g_reg
        if (i == 0) begin : g_zero
            assign rf[i] = '0;
        end else begin : g_store
            logic [W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (we1 && wa1 == AW'(i))
                    q <= wd1;
                else if (we2 && wa2 == AW'(i))
                    q <= wd2;
            end
            assign rf[i] = q;
        end
    end

    assign rd_a = rf[ra_a];
    assign rd_b = rf[ra_b];

    AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (ra_a == '0) |-> (rd_a == '0)); // R9

    AST_PORT1_WINS: assert property (@(posedge clk) disable iff (rst)
        (we1 && we2 && wa1 == wa2 && wa1 != '0) |=> (rf[$past(wa1)] == $past(wd1))); // R8
endmodule

// File: rtl/mcl_alu.sv
module mcl_alu #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   op,
    output logic [W-1:0] y
);
    always_comb begin
        case (op)
            2'b01:   y = a - b;
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/mcl_ctrl.sv
module mcl_ctrl
    import mcl_pkg::*;
#(
    parameter bit DUAL_WB = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [5:0] op,
    output ctl_t       ctl
);
    state_t state, nxt;
    logic   is_pi;

    assign is_pi = (op == OP_LOADPI);

    always_ff @(posedge clk) begin
        if (rst) state <= S_FETCH;
        else     state <= nxt;
    end

    always_comb begin
        ctl = '0;
        nxt = S_FETCH;
        case (state)
            S_FETCH: begin
                ctl.ir_we  = 1'b1;
                ctl.pc_we  = 1'b1;
                ctl.src_b  = 2'b01;
                nxt        = S_DECODE;
            end
            S_DECODE: begin
                ctl.ab_we     = 1'b1;
                ctl.aluout_we = 1'b1;
                ctl.src_b     = 2'b10;
                nxt           = op_known(op) ? S_ADDR : S_FETCH;
            end
            S_ADDR: begin
                ctl.aluout_we = 1'b1;
                ctl.src_a     = 1'b1;
                ctl.src_b     = 2'b10;
                nxt           = S_MEM;
            end
            S_MEM: begin
                ctl.iord   = 1'b1;
                ctl.mdr_we = 1'b1;
                if (is_pi) begin
                    ctl.aluout_we = 1'b1;
                    ctl.src_a     = 1'b1;
                    ctl.src_b     = 2'b01;
                end
                nxt = (is_pi && DUAL_WB) ? S_WBBOTH : S_WBLOAD;
            end
            S_WBLOAD: begin
                ctl.reg_dst    = 2'b00;
                ctl.mem_to_reg = 1'b1;
                ctl.reg_we     = 1'b1;
                if (is_pi && !DUAL_WB) begin
                    nxt = S_WBBASE;
                end else begin
                    ctl.done = 1'b1;
                    nxt      = S_FETCH;
                end
            end
            S_WBBOTH: begin
                ctl.reg_dst    = 2'b00;
                ctl.mem_to_reg = 1'b1;
                ctl.reg_we     = 1'b1;
                ctl.reg_we2    = 1'b1;
                ctl.done       = 1'b1;
                nxt            = S_FETCH;
            end
            S_WBBASE: begin
                ctl.reg_dst = 2'b10;
                ctl.reg_we  = 1'b1;
                ctl.done    = 1'b1;
                nxt         = S_FETCH;
            end
            default: nxt = S_FETCH;
        endcase
    end

    AST_BASE_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        (state == S_WBBASE) |-> ($past(state) == S_WBLOAD)); // R6

    AST_DONE_THEN_FETCH: assert property (@(posedge clk) disable iff (rst)
        ctl.done |=> (state == S_FETCH)); // R7

    AST_BAD_OP_SHORT: assert property (@(posedge clk) disable iff (rst)
        (state == S_DECODE && !op_known(op)) |=> (state == S_FETCH)); // R10
endmodule

// File: rtl/mcl_core.sv
module mcl_core
    import mcl_pkg::*;
#(
    parameter bit DUAL_WB = 1'b1,
    parameter int NREG    = 32,
    localparam int RAW    = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] mem_addr,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            mem_data_rd,
    output logic            done
);
    ctl_t            ctl;
    instr_t          ir;
    logic [XLEN-1:0] pc, a_q, b_q, aluout, mdr;
    logic [XLEN-1:0] rd_a, rd_b, alu_a, alu_b, alu_y, imm_x, wd1;
    logic [RAW-1:0]  wa1;
    logic            we2;

    assign imm_x = sext16(ir.imm);

    mcl_ctrl #(.DUAL_WB(DUAL_WB)) u_ctrl (
        .clk (clk),
        .rst (rst),
        .op  (ir.op),
        .ctl (ctl)
    );

    assign alu_a = ctl.src_a ? a_q : pc;
    always_comb begin
        case (ctl.src_b)
            2'b00:   alu_b = b_q;
            2'b01:   alu_b = XLEN'(4);
            default: alu_b = imm_x;
        endcase
    end

    mcl_alu #(.W(XLEN)) u_alu (
        .a  (alu_a),
        .b  (alu_b),
        .op (ctl.alu_op),
        .y  (alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc     <= '0;
            ir     <= '0;
            a_q    <= '0;
            b_q    <= '0;
            aluout <= '0;
            mdr    <= '0;
        end else begin
            if (ctl.pc_we)     pc     <= alu_y;
            if (ctl.ir_we)     ir     <= instr_t'(mem_rdata);
            if (ctl.ab_we)     a_q    <= rd_a;
            if (ctl.ab_we)     b_q    <= rd_b;
            if (ctl.aluout_we) aluout <= alu_y;
            if (ctl.mdr_we)    mdr    <= mem_rdata;
        end
    end

    always_comb begin
        case (ctl.reg_dst)
            2'b01:   wa1 = RAW'(ir.imm[15:11]);
            2'b10:   wa1 = RAW'(ir.rs);
            default: wa1 = RAW'(ir.rt);
        endcase
    end
    assign wd1 = ctl.mem_to_reg ? mdr : aluout;

    if (DUAL_WB) begin : g_dual
        assign we2 = ctl.reg_we2;
    end else begin : g_single
        assign we2 = 1'b0;
    end

    mcl_regfile #(.W(XLEN), .N(NREG)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .ra_a (RAW'(ir.rs)),
        .ra_b (RAW'(ir.rt)),
        .rd_a (rd_a),
        .rd_b (rd_b),
        .we1  (ctl.reg_we),
        .wa1  (wa1),
        .wd1  (wd1),
        .we2  (we2),
        .wa2  (RAW'(ir.rs)),
        .wd2  (aluout)
    );

    assign mem_addr    = ctl.iord ? aluout : pc;
    assign mem_data_rd = ctl.iord;
    assign done        = ctl.done;

    AST_BASE_HELD: assert property (@(posedge clk) disable iff (rst)
        ctl.iord |=> (a_q == $past(a_q))); // R3

    AST_WB2_PAIRED: assert property (@(posedge clk) disable iff (rst)
        we2 |-> ctl.reg_we); // R5
endmodule

// File: tb/mcl_core_test.sv
module mcl_core_test;
    typedef struct {
        logic [31:0] v;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] addr_d, addr_s, rdata_d, rdata_s;
    logic        drd_d, drd_s, done_d, done_s;
    logic [31:0] mem [64];
    int          cyc = 0;
    int          nchk = 0;
    int          nerr = 0;
    int          t_d = -1;
    int          t_s = -1;
    exp_t        qa_d[$], qa_s[$], qd_d[$], qd_s[$];

    always #4 clk = ~clk;

    assign rdata_d = mem[addr_d[7:2]];
    assign rdata_s = mem[addr_s[7:2]];

    mcl_core #(.DUAL_WB(1'b1)) uut (
        .clk(clk), .rst(rst), .mem_addr(addr_d), .mem_rdata(rdata_d),
        .mem_data_rd(drd_d), .done(done_d)
    );

    mcl_core #(.DUAL_WB(1'b0)) uut_seq (
        .clk(clk), .rst(rst), .mem_addr(addr_s), .mem_rdata(rdata_s),
        .mem_data_rd(drd_s), .done(done_s)
    );

    always @(posedge clk) if (!rst) cyc <= cyc + 1;

    function automatic logic [31:0] enc(input logic [5:0] op, input int rs, input int rt,
                                        input int off);
        return {op, 5'(rs), 5'(rt), 16'(off)};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // driver: kind 0 plain load, 1 post-increment load, 2 undefined opcode
    task automatic drive(input int kind, input logic [31:0] ad, input logic [31:0] as_,
                         input string tag);
        exp_t e;
        if (kind == 2) begin
            t_d += 2;
            t_s += 2;
        end else begin
            e.tag = tag;
            e.v = ad;  qa_d.push_back(e);
            e.v = as_; qa_s.push_back(e);
            t_d += 5;
            t_s += (kind == 1) ? 6 : 5;
            e.tag = (kind == 1) ? {tag, " R5"} : {tag, " R7"};
            e.v = 32'(t_d); qd_d.push_back(e);
            e.tag = (kind == 1) ? {tag, " R6"} : {tag, " R7"};
            e.v = 32'(t_s); qd_s.push_back(e);
        end
    endtask

    task automatic pop_cmp(ref exp_t q[$], input logic [31:0] act, input string what);
        exp_t e;
        if (q.size() == 0) begin
            check(1'b0, "R10", {what, " unexpected event"}, act, 32'hffff_ffff);
        end else begin
            e = q.pop_front();
            check(act == e.v, e.tag, what, act, e.v);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (drd_d)  pop_cmp(qa_d, addr_d, "dual data address");
            if (drd_s)  pop_cmp(qa_s, addr_s, "seq data address");
            if (done_d) pop_cmp(qd_d, 32'(cyc), "dual done cycle");
            if (done_s) pop_cmp(qd_s, 32'(cyc), "seq done cycle");
        end
    end

    initial begin
        localparam logic [5:0] LD = 6'b100011;
        localparam logic [5:0] PI = 6'b111111;
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        mem[32] = 32'h84;
        mem[33] = 32'h40;
        mem[35] = 32'hA0;
        mem[36] = 32'h98;
        mem[40] = 32'hB0;
        mem[0]  = enc(LD, 0, 7, 32'h80);     // r7 = 0x84
        mem[1]  = enc(PI, 7, 6, 8);          // r6 = 0xA0, r7 = 0x88
        mem[2]  = enc(LD, 7, 1, 4);          // r1 = 0xA0
        mem[3]  = enc(LD, 6, 2, 0);
        mem[4]  = enc(6'b000100, 7, 7, 16);  // undefined
        mem[5]  = enc(PI, 7, 3, -4);         // r7 = 0x8C
        mem[6]  = enc(LD, 7, 4, 0);
        mem[7]  = enc(PI, 1, 1, 0);          // same base and destination
        mem[8]  = enc(LD, 1, 2, 0);
        mem[9]  = enc(PI, 0, 8, 32'h90);     // r8 = 0x98, r0 stays 0
        mem[10] = enc(LD, 0, 9, 32'h80);
        mem[11] = enc(LD, 0, 0, 32'h84);     // write to r0 ignored
        mem[12] = enc(LD, 0, 10, 32'h80);
        mem[13] = enc(LD, 8, 11, 0);

        drive(0, 32'h80, 32'h80, "R1");
        drive(1, 32'h8C, 32'h8C, "R3");
        drive(0, 32'h8C, 32'h8C, "R3 base+4");
        drive(0, 32'hA0, 32'hA0, "R1 loaded value");
        drive(2, 0, 0, "R10");
        drive(1, 32'h84, 32'h84, "R4 R10");
        drive(0, 32'h8C, 32'h8C, "R3 R4");
        drive(1, 32'hA0, 32'hA0, "R8");
        drive(0, 32'hB0, 32'hA4, "R8 winner");
        drive(1, 32'h90, 32'h90, "R9");
        drive(0, 32'h80, 32'h80, "R9 port2 to r0");
        drive(0, 32'h84, 32'h84, "R9");
        drive(0, 32'h80, 32'h80, "R9 port1 to r0");
        drive(0, 32'h98, 32'h98, "R3 R9");

        repeat (3) @(negedge clk);
        // R2: reset state
        check(addr_d == 32'h0 && addr_s == 32'h0, "R2", "reset address", addr_d | addr_s, 0);
        check(!done_d && !done_s, "R2", "reset done", {30'h0, done_d, done_s}, 0);
        check(!drd_d && !drd_s, "R2", "reset data read", {30'h0, drd_d, drd_s}, 0);
        rst = 1'b0;

        while ((qd_d.size() != 0 || qd_s.size() != 0) && cyc < 2000) @(negedge clk);
        if (cyc >= 2000) check(1'b0, "R7", "watchdog expired", 32'(cyc), 2000);
        repeat (2) @(negedge clk);
        check(qa_d.size() == 0, "R1", "dual reads left", 32'(qa_d.size()), 0);
        check(qa_s.size() == 0, "R1", "seq reads left", 32'(qa_s.size()), 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule